// File: doc/BRIEF.md
# Serial Port DMA Request Grouper

This block sits between a serial peripheral data path and a DMA engine. It is loaded with the number of words a transfer should move. It watches a one-cycle strobe that pulses once for every word the port shifts. It does not ask the DMA engine for service on every word. Instead it collects words into groups of four (the group size is a parameter) and raises one service request for each complete group. A transfer whose length is not a multiple of the group size ends with a single shorter request that covers only the leftover words.

Each request stays up, with its word count shown beside it, until the DMA engine acknowledges it. The acknowledge takes that many words off the remaining count. A done flag reports that every programmed word has been requested and acknowledged.

If the programmed count is larger than the number of words the port actually moves, the last group never fills. Its request is never raised and done stays low. Software must program the count to match the real transfer length. Loading a new count abandons any partial group and any pending request.

Top module: `spi_dma_grouper`

## Requirements
- R1: After reset `req_o` is 0, `req_len_o` is 0 and `done_o` is 1.
- R2: While at least four words remain, a request with `req_len_o` = 4 is raised on the clock edge that samples the fourth collected `word_i` pulse. A count of 16 yields exactly four such requests.
- R3: When fewer than four words remain, one request is raised as soon as that many words have been collected, and `req_len_o` equals the remainder. A count of 18 yields four requests of 4 and then one request of 2. A count of 3 yields a single request of 3.
- R4: A raised request keeps `req_o` = 1 and an unchanged `req_len_o` until `ack_i` is sampled high. `req_o` is 0 after that edge, and the remaining count drops by the acknowledged length.
- R5: `done_o` goes to 1 on the edge that acknowledges the last words. A loaded count of 0 sets `done_o` = 1 and never raises a request. `req_o` is never 1 while `done_o` is 1.
- R6: If fewer words arrive than were programmed, the final incomplete group raises no request and `done_o` stays 0.
- R7: A `load_i` pulse clears any pending request and any partially collected group. It sets `done_o` to 0 when the new count is nonzero, and it takes priority over `word_i` and `ack_i` in the same cycle.
- R8: `word_i` pulses beyond the words still outstanding, counted as remaining minus pending, are ignored. They never lead to an extra request.
- R9: A `word_i` pulse in the same cycle as an acknowledging `ack_i` is counted toward the next group.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load_i | input | 1 | Load strobe for a new transfer count |
| count_i | input | CNT_W | Word count to load |
| word_i | input | 1 | One pulse per word moved by the port |
| ack_i | input | 1 | DMA acknowledge of the pending request |
| req_o | output | 1 | DMA service request |
| req_len_o | output | LEN_W | Words covered by the pending request |
| done_o | output | 1 | All programmed words requested and acknowledged |

## Verification
The collision of interest is a word strobe landing in the same cycle as the acknowledge of a pending request. The acknowledge retires the request and lowers the remaining count, while the word strobe must still be credited to the following group. The bench provokes this by holding `word_i` and `ack_i` high together on the cycle that retires a full group. It then sends exactly three more words and expects the next four-word request on the third of them; a lost word would delay the request by one pulse. A second overlap, a load arriving while a request is pending, is judged by checking that the request drops and that four fresh words are needed before the next one.

// File: rtl/sdg_pkg.sv
`timescale 1ns/1ps
package sdg_pkg;
  // Size of the next group: a full group, or whatever is left.
  function automatic int unsigned next_group(input int unsigned left, input int unsigned grp);
    return (left < grp) ? left : grp;
  endfunction
endpackage

// File: rtl/sdg_remain.sv
`timescale 1ns/1ps
module sdg_remain #(
  parameter int CNT_W = 16,
  parameter int LEN_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic             fire_i,
  input  logic [LEN_W-1:0] len_i,
  output logic [CNT_W-1:0] rem_o,
  output logic             done_o
);
  logic [CNT_W-1:0] len_ext;
  assign len_ext = CNT_W'(len_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      rem_o  <= '0;
      done_o <= 1'b1;
    end else if (load_i) begin
      rem_o  <= count_i;
      done_o <= (count_i == '0);
    end else if (fire_i) begin
      rem_o  <= rem_o - len_ext;
      done_o <= (rem_o == len_ext);
    end
  end

  AST_REMAIN_DEC: assert property (@(posedge clk) disable iff (rst)
    fire_i && !load_i |=> rem_o == $past(rem_o) - CNT_W'($past(len_i))); // R4
  AST_DONE_EMPTY: assert property (@(posedge clk) disable iff (rst)
    done_o |-> rem_o == '0); // R5
endmodule

// File: rtl/sdg_tally.sv
`timescale 1ns/1ps
module sdg_tally #(
  parameter int CNT_W = 16,
  parameter int LEN_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_i,
  input  logic             word_i,
  input  logic [CNT_W-1:0] room_i,
  input  logic             take_i,
  input  logic [LEN_W-1:0] take_len_i,
  output logic [CNT_W-1:0] tally_inc_o,
  output logic [CNT_W-1:0] tally_o
);
  logic accept;
  // Words past the outstanding total are dropped.
  assign accept      = word_i && (tally_o < room_i);
  assign tally_inc_o = tally_o + CNT_W'(accept);

  always_ff @(posedge clk) begin
    if (rst || load_i)
      tally_o <= '0;
    else if (take_i)
      tally_o <= tally_inc_o - CNT_W'(take_len_i);
    else
      tally_o <= tally_inc_o;
  end

  AST_TALLY_BOUND: assert property (@(posedge clk) disable iff (rst)
    tally_o <= room_i); // R8
  AST_LOAD_EMPTY: assert property (@(posedge clk) disable iff (rst)
    load_i |=> tally_o == '0); // R7
endmodule

// File: rtl/sdg_req.sv
`timescale 1ns/1ps
module sdg_req
  import sdg_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int LEN_W = 3,
  parameter int GRP   = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_i,
  input  logic             ack_i,
  input  logic [CNT_W-1:0] rem_i,
  input  logic [CNT_W-1:0] tally_inc_i,
  output logic             req_o,
  output logic [LEN_W-1:0] len_o,
  output logic             raise_o,
  output logic [LEN_W-1:0] need_o,
  output logic             fire_o
);
  always_comb begin
    need_o = LEN_W'(next_group(32'(rem_i), GRP));
  end

  assign raise_o = !req_o && !load_i && (need_o != '0) && (tally_inc_i >= CNT_W'(need_o));
  assign fire_o  = req_o && ack_i && !load_i;

  always_ff @(posedge clk) begin
    if (rst || load_i) begin
      req_o <= 1'b0;
      len_o <= '0;
    end else if (fire_o) begin
      req_o <= 1'b0;
    end else if (raise_o) begin
      req_o <= 1'b1;
      len_o <= need_o;
    end
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    req_o && !ack_i && !load_i |=> req_o && $stable(len_o)); // R4
  AST_ACK_DROP: assert property (@(posedge clk) disable iff (rst)
    req_o && ack_i |=> !req_o); // R4
  AST_LEN_RANGE: assert property (@(posedge clk) disable iff (rst)
    req_o |-> (len_o != '0) && (len_o <= LEN_W'(GRP))); // R2
  AST_TAIL_LAST: assert property (@(posedge clk) disable iff (rst)
    req_o && (len_o < LEN_W'(GRP)) |-> rem_i == CNT_W'(len_o)); // R3
  AST_LOAD_CLEAR: assert property (@(posedge clk) disable iff (rst)
    load_i |=> !req_o); // R7
endmodule

// File: rtl/spi_dma_grouper.sv
`timescale 1ns/1ps
module spi_dma_grouper #(
  parameter int CNT_W = 16,
  parameter int GRP   = 4,
  localparam int LEN_W = $clog2(GRP + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic             word_i,
  input  logic             ack_i,
  output logic             req_o,
  output logic [LEN_W-1:0] req_len_o,
  output logic             done_o
);
  logic [CNT_W-1:0] rem;
  logic [CNT_W-1:0] room;
  logic [CNT_W-1:0] tally_inc;
  logic [CNT_W-1:0] tally;
  logic             raise;
  logic             fire;
  logic [LEN_W-1:0] need;

  // Words not yet covered by a raised request.
  assign room = rem - (req_o ? CNT_W'(req_len_o) : '0);

  sdg_remain #(.CNT_W(CNT_W), .LEN_W(LEN_W)) u_remain (
    .clk(clk), .rst(rst), .load_i(load_i), .count_i(count_i),
    .fire_i(fire), .len_i(req_len_o), .rem_o(rem), .done_o(done_o)
  );

  sdg_tally #(.CNT_W(CNT_W), .LEN_W(LEN_W)) u_tally (
    .clk(clk), .rst(rst), .load_i(load_i), .word_i(word_i), .room_i(room),
    .take_i(raise), .take_len_i(need), .tally_inc_o(tally_inc), .tally_o(tally)
  );

  sdg_req #(.CNT_W(CNT_W), .LEN_W(LEN_W), .GRP(GRP)) u_req (
    .clk(clk), .rst(rst), .load_i(load_i), .ack_i(ack_i), .rem_i(rem),
    .tally_inc_i(tally_inc), .req_o(req_o), .len_o(req_len_o),
    .raise_o(raise), .need_o(need), .fire_o(fire)
  );

  AST_DONE_NO_REQ: assert property (@(posedge clk) disable iff (rst)
    done_o |-> !req_o); // R5
  AST_RESET_STATE: assert property (@(posedge clk)
    $past(rst) |-> !req_o && done_o); // R1
endmodule

// File: tb/sim_spi_dma_grouper.sv
`timescale 1ns/1ps
module sim_spi_dma_grouper;
  localparam int CNT_W = 16;
  localparam int GRP   = 4;
  localparam int LEN_W = $clog2(GRP + 1);

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             load_i = 1'b0;
  logic [CNT_W-1:0] count_i = '0;
  logic             word_i = 1'b0;
  logic             ack_i = 1'b0;
  logic             req_o;
  logic [LEN_W-1:0] req_len_o;
  logic             done_o;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  spi_dma_grouper #(.CNT_W(CNT_W), .GRP(GRP)) u0 (
    .clk(clk), .rst(rst), .load_i(load_i), .count_i(count_i),
    .word_i(word_i), .ack_i(ack_i), .req_o(req_o), .req_len_o(req_len_o),
    .done_o(done_o)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 20000) begin
      fails = fails + 1;
      $display("FAIL watchdog: run hung, actual %0d cycles expected < 20000", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    checks = checks + 1;
    if (act != exp) begin
      fails = fails + 1;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Drive one cycle of inputs at the falling edge, settle past the rising edge.
  task automatic cyc(input logic w, input logic a, input logic l, input int c);
    @(negedge clk);
    word_i = w; ack_i = a; load_i = l; count_i = CNT_W'(c);
    @(posedge clk);
    #1;
    word_i = 1'b0; ack_i = 1'b0; load_i = 1'b0;
  endtask

  task automatic load(input int c);
    cyc(1'b0, 1'b0, 1'b1, c);
  endtask

  task automatic words(input int n);
    for (int i = 0; i < n; i++) cyc(1'b1, 1'b0, 1'b0, 0);
  endtask

  task automatic ack();
    cyc(1'b0, 1'b1, 1'b0, 0);
  endtask

  // Three words without a request, the fourth raises one of length 4.
  task automatic full_group(input string tag);
    words(3);
    check({tag, " R2 no req before 4th word"}, req_o, 0);
    words(1);
    check({tag, " R2 req on 4th word"}, req_o, 1);
    check({tag, " R2 len"}, req_len_o, 4);
    cyc(1'b0, 1'b0, 1'b0, 0);
    check({tag, " R4 req held"}, req_o, 1);
    check({tag, " R4 len held"}, req_len_o, 4);
    ack();
    check({tag, " R4 req dropped"}, req_o, 0);
  endtask

  task automatic t_reset();
    check("R1 req after reset", req_o, 0);
    check("R1 len after reset", req_len_o, 0);
    check("R1 done after reset", done_o, 1);
  endtask

  task automatic t_count16();
    load(16);
    check("R7 done low after load 16", done_o, 0);
    check("R7 req low after load 16", req_o, 0);
    for (int g = 0; g < 4; g++) begin
      full_group("c16");
      check("c16 R5 done timing", done_o, (g == 3) ? 1 : 0);
    end
    words(4);
    check("c16 R2 no fifth request", req_o, 0);
  endtask

  task automatic t_count18();
    load(18);
    for (int g = 0; g < 4; g++) full_group("c18");
    check("c18 R5 not done before tail", done_o, 0);
    words(1);
    check("c18 R3 no req after 1 tail word", req_o, 0);
    words(1);
    check("c18 R3 tail req", req_o, 1);
    check("c18 R3 tail len", req_len_o, 2);
    ack();
    check("c18 R5 done after tail ack", done_o, 1);
    check("c18 R5 req low when done", req_o, 0);
  endtask

  task automatic t_count3();
    load(3);
    words(2);
    check("c3 R3 no req after 2 words", req_o, 0);
    words(1);
    check("c3 R3 single req", req_o, 1);
    check("c3 R3 single len", req_len_o, 3);
    ack();
    check("c3 R5 done", done_o, 1);
  endtask

  task automatic t_zero();
    load(0);
    check("zero R5 done at once", done_o, 1);
    words(5);
    check("zero R5 no req", req_o, 0);
  endtask

  task automatic t_short();
    load(8);
    full_group("short");
    words(2);
    for (int i = 0; i < 5; i++) cyc(1'b0, 1'b0, 1'b0, 0);
    check("short R6 last group never requested", req_o, 0);
    check("short R6 done stays low", done_o, 0);
  endtask

  task automatic t_reload();
    load(8);
    words(4);
    check("reload R2 pending", req_o, 1);
    load(5);
    check("reload R7 req cleared", req_o, 0);
    check("reload R7 done low", done_o, 0);
    words(3);
    check("reload R7 partial cleared", req_o, 0);
    words(1);
    check("reload R7 fresh group req", req_o, 1);
    check("reload R7 fresh group len", req_len_o, 4);
    ack();
    words(1);
    check("reload R3 tail of 1", req_len_o, 1);
    check("reload R3 tail req", req_o, 1);
    // load collides with word and ack: load wins
    cyc(1'b1, 1'b1, 1'b1, 4);
    check("reload R7 load wins req", req_o, 0);
    check("reload R7 load wins done", done_o, 0);
    words(3);
    check("reload R7 word in load cycle dropped", req_o, 0);
  endtask

  task automatic t_over();
    load(2);
    words(2);
    check("over R3 req len 2", req_len_o, 2);
    words(3);
    check("over R8 req still pending", req_o, 1);
    ack();
    check("over R5 done", done_o, 1);
    words(4);
    check("over R8 extra words no req", req_o, 0);
  endtask

  task automatic t_collide();
    load(8);
    words(4);
    check("coll R2 req", req_o, 1);
    cyc(1'b1, 1'b1, 1'b0, 0);
    check("coll R4 req dropped", req_o, 0);
    words(2);
    check("coll R9 no req after 1+2", req_o, 0);
    words(1);
    check("coll R9 req after 1+3", req_o, 1);
    check("coll R9 len", req_len_o, 4);
    ack();
    check("coll R5 done", done_o, 1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    @(posedge clk);
    #1;
    t_reset();
    t_count16();
    t_count18();
    t_count3();
    t_zero();
    t_short();
    t_reload();
    t_over();
    t_collide();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule